// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Status Flags

This block is the combinational datapath heart of a small accumulator machine. In one evaluation it takes the accumulator byte, a second operand byte, the current status flag vector and an operation code. It returns the new accumulator value and the new flag vector. The surrounding core keeps the flag register, picks the operand from its register file or an immediate, and writes both outputs back. Decoding, storage and the decimal-adjust step stay outside this block.

Eight two-operand operations use codes 0 to 7, so the low three bits of an arithmetic opcode can drive the code directly. Six single-operand operations act on the accumulator or on the flags alone. Each operation updates some flags, forces some to fixed values and passes the rest through from the incoming vector. The parity/overflow flag reports even parity for the logic group and signed overflow for the arithmetic group.

The data width and the half-carry position are parameters. The defaults give an 8-bit unit with the half-carry taken out of bit 3.

Top module: `acc_alu`

## Requirements
- R1: The operation code `op_i` maps as follows: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 XOR, 6 OR, 7 compare, 8 increment, 9 decrement, 10 negate, 11 complement, 12 set carry, 13 complement carry, 14 and 15 reserved. The flag vector bits are [5] sign S, [4] zero Z, [3] half-carry H, [2] parity/overflow PV, [1] subtract N, [0] carry C. Carry-in is `flags_i[0]`.
- R2: Add and add-with-carry return acc+opnd (+C for add-with-carry). C is the carry out of bit 7, H is the carry out of bit 3, PV is two's-complement overflow, and N is 0.
- R3: Subtract and subtract-with-borrow return acc-opnd (-C for the borrow form). C is the borrow out of bit 7, H is the borrow out of bit 3, and PV is set when the operands differ in sign and the result's sign differs from acc's. N is 1.
- R4: Compare sets every flag exactly as subtract does, but returns the accumulator unchanged.
- R5: AND, XOR and OR return the bitwise result. PV is 1 when the result holds an even number of one bits. N and C are 0. H is 1 for AND and 0 for XOR and OR.
- R6: For every operation in R2 to R5 and R7, R8, S equals bit 7 of the computed value and Z is 1 exactly when that value is zero. For compare, the computed value is the difference.
- R7: Increment returns acc+1 with N=0, and decrement returns acc-1 with N=1. Both set H from the carry or borrow at bit 3, set PV on signed overflow (acc 0x7F on increment, 0x80 on decrement), and copy C from the input.
- R8: Negate returns 0-acc with N=1. C is 1 unless acc is 0, H is 1 unless the low nibble of acc is 0, and PV is 1 only for acc 0x80.
- R9: Complement returns ~acc and sets H and N to 1. S, Z, PV and C pass through.
- R10: Set-carry returns acc, sets C to 1 and clears H and N. Complement-carry returns acc, inverts C and clears N. In both operations all other flags pass through.
- R11: Reserved codes 14 and 15 return acc and `flags_i` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand |
| op_i | input | 4 | Operation code (R1) |
| flags_i | input | 6 | Current flag vector {S,Z,H,PV,N,C} |
| res_o | output | 8 | Result, meant for the accumulator |
| flags_o | output | 6 | New flag vector {S,Z,H,PV,N,C} |

## Verification
The bench builds the unit with its defaults: an 8-bit width, the half-carry at bit 3, and the reduction form of the parity tree. At this size every accumulator and operand pair can be applied to each two-operand code. The incoming flag vector is varied with the operands, so both carry-in values reach every code. Each single-operand code is swept over every accumulator value against all 64 incoming flag vectors, which exercises every pass-through and forced flag. This sweep reaches the corners directly: 0x7F and 0x80 overflow, nibble wrap at 0x0F and 0x10, negation of zero and of 0x80, and compare results that are equal or one apart.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
   // Operation codes; codes 0..7 follow the three-bit arithmetic field order
   typedef enum logic [3:0] {
      OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBC = 4'd3,
      OP_AND = 4'd4, OP_XOR = 4'd5, OP_OR  = 4'd6, OP_CMP = 4'd7,
      OP_INC = 4'd8, OP_DEC = 4'd9, OP_NEG = 4'd10, OP_CPL = 4'd11,
      OP_SCF = 4'd12, OP_CCF = 4'd13, OP_RS0 = 4'd14, OP_RS1 = 4'd15
   } op_e;

   // Flag vector bit positions
   localparam int FL_S  = 5;
   localparam int FL_Z  = 4;
   localparam int FL_H  = 3;
   localparam int FL_PV = 2;
   localparam int FL_N  = 1;
   localparam int FL_C  = 0;
   localparam int FL_W  = 6;

   // Logic unit selector
   typedef enum logic [1:0] {LG_AND = 2'd0, LG_XOR = 2'd1, LG_OR = 2'd2} lsel_e;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
   parameter int WIDTH  = 8,
   parameter int HALF_W = 4
) (
   input  logic [WIDTH-1:0] x_i,
   input  logic [WIDTH-1:0] y_i,
   input  logic             sub_i,   // 1: x - y - cin, 0: x + y + cin
   input  logic             cin_i,   // carry (add) or borrow (subtract)
   output logic [WIDTH-1:0] sum_o,
   output logic             co_o,    // carry or borrow out of the top bit
   output logic             hc_o,    // carry or borrow out of bit HALF_W-1
   output logic             ov_o
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] y_eff;
   logic             ci_eff;
   logic [HALF_W:0]  lo_sum;
   logic [WIDTH:0]   full_sum;

   // Subtraction runs as x + ~y + ~borrow; carries then read as inverted borrows
   assign y_eff    = sub_i ? ~y_i : y_i;
   assign ci_eff   = sub_i ? ~cin_i : cin_i;
   assign lo_sum   = {1'b0, x_i[HALF_W-1:0]} + {1'b0, y_eff[HALF_W-1:0]}
                   + {{HALF_W{1'b0}}, ci_eff};
   assign full_sum = {1'b0, x_i} + {1'b0, y_eff} + {{WIDTH{1'b0}}, ci_eff};

   assign sum_o = full_sum[MSB:0];
   assign co_o  = full_sum[WIDTH] ^ sub_i;
   assign hc_o  = lo_sum[HALF_W] ^ sub_i;
   assign ov_o  = (x_i[MSB] == y_eff[MSB]) && (sum_o[MSB] != x_i[MSB]);
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
   import acc_alu_pkg::*;
#(
   parameter int WIDTH     = 8,
   parameter bit PAR_CHAIN = 1'b0   // 1: ripple xor chain, 0: reduction operator
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  lsel_e            sel_i,
   output logic [WIDTH-1:0] res_o,
   output logic             par_even_o
);
   always_comb begin
      case (sel_i)
         LG_AND:  res_o = a_i & b_i;
         LG_XOR:  res_o = a_i ^ b_i;
         default: res_o = a_i | b_i;
      endcase
   end

   generate
      if (PAR_CHAIN) begin : g_chain
         logic [WIDTH:0] px;
         assign px[0] = 1'b0;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign px[i+1] = px[i] ^ res_o[i];
         end
         assign par_even_o = ~px[WIDTH];
      end else begin : g_reduce
         assign par_even_o = ~(^res_o);
      end
   endgenerate
endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int WIDTH     = 8,
   parameter int HALF_W    = 4,
   parameter bit PAR_CHAIN = 1'b0
) (
   input  logic [WIDTH-1:0] acc_i,
   input  logic [WIDTH-1:0] opnd_i,
   input  logic [3:0]       op_i,
   input  logic [FL_W-1:0]  flags_i,
   output logic [WIDTH-1:0] res_o,
   output logic [FL_W-1:0]  flags_o
);
   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2 || HALF_W < 1 || HALF_W >= WIDTH) begin : g_bad_cfg
         $error("acc_alu: HALF_W must lie in 1..WIDTH-1");
      end
   endgenerate

   op_e              op;
   logic [WIDTH-1:0] as_x, as_y, as_sum;
   logic             as_sub, as_cin, as_co, as_hc, as_ov;
   logic [WIDTH-1:0] lg_res;
   logic             lg_par;
   lsel_e            lg_sel;
   logic             cin;

   assign op  = op_e'(op_i);
   assign cin = flags_i[FL_C];

   // Operand routing into the shared adder
   always_comb begin
      as_x   = acc_i;
      as_y   = opnd_i;
      as_sub = 1'b0;
      as_cin = 1'b0;
      case (op)
         OP_ADC: as_cin = cin;
         OP_SUB, OP_CMP: as_sub = 1'b1;
         OP_SBC: begin as_sub = 1'b1; as_cin = cin; end
         OP_INC: begin as_y = '0; as_cin = 1'b1; end
         OP_DEC: begin as_y = '0; as_sub = 1'b1; as_cin = 1'b1; end
         OP_NEG: begin as_x = '0; as_y = acc_i; as_sub = 1'b1; end
         default: ;
      endcase
   end

   assign lg_sel = (op == OP_AND) ? LG_AND : (op == OP_XOR) ? LG_XOR : LG_OR;

   acc_alu_addsub #(.WIDTH(WIDTH), .HALF_W(HALF_W)) u_addsub (
      .x_i(as_x), .y_i(as_y), .sub_i(as_sub), .cin_i(as_cin),
      .sum_o(as_sum), .co_o(as_co), .hc_o(as_hc), .ov_o(as_ov)
   );

   acc_alu_logic #(.WIDTH(WIDTH), .PAR_CHAIN(PAR_CHAIN)) u_logic (
      .a_i(acc_i), .b_i(opnd_i), .sel_i(lg_sel),
      .res_o(lg_res), .par_even_o(lg_par)
   );

   // Result and flag assembly per operation
   always_comb begin
      res_o   = acc_i;
      flags_o = flags_i;
      case (op)
         OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_NEG: begin
            res_o          = (op == OP_CMP) ? acc_i : as_sum;
            flags_o[FL_S]  = as_sum[MSB];
            flags_o[FL_Z]  = (as_sum == '0);
            flags_o[FL_H]  = as_hc;
            flags_o[FL_PV] = as_ov;
            flags_o[FL_N]  = as_sub;
            flags_o[FL_C]  = as_co;
         end
         OP_INC, OP_DEC: begin
            res_o          = as_sum;
            flags_o[FL_S]  = as_sum[MSB];
            flags_o[FL_Z]  = (as_sum == '0);
            flags_o[FL_H]  = as_hc;
            flags_o[FL_PV] = as_ov;
            flags_o[FL_N]  = as_sub;
         end
         OP_AND, OP_XOR, OP_OR: begin
            res_o          = lg_res;
            flags_o[FL_S]  = lg_res[MSB];
            flags_o[FL_Z]  = (lg_res == '0);
            flags_o[FL_H]  = (op == OP_AND);
            flags_o[FL_PV] = lg_par;
            flags_o[FL_N]  = 1'b0;
            flags_o[FL_C]  = 1'b0;
         end
         OP_CPL: begin
            res_o         = ~acc_i;
            flags_o[FL_H] = 1'b1;
            flags_o[FL_N] = 1'b1;
         end
         OP_SCF: begin
            flags_o[FL_C] = 1'b1;
            flags_o[FL_H] = 1'b0;
            flags_o[FL_N] = 1'b0;
         end
         OP_CCF: begin
            flags_o[FL_C] = ~flags_i[FL_C];
            flags_o[FL_N] = 1'b0;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
   import acc_alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input logic [WIDTH-1:0] acc_i,
   input logic [WIDTH-1:0] opnd_i,
   input logic [3:0]       op_i,
   input logic [FL_W-1:0]  flags_i,
   input logic [WIDTH-1:0] res_o,
   input logic [FL_W-1:0]  flags_o
);
   always_comb begin
      // R4: compare leaves the accumulator value as it was
      if (op_i == 4'd7) p_cmp_keeps_acc_r4: assert (res_o == acc_i);
      // R7: increment and decrement carry the incoming C through
      if (op_i == 4'd8 || op_i == 4'd9)
         p_incdec_keeps_c_r7: assert (flags_o[FL_C] == flags_i[FL_C]);
      // R5: logic group clears N and C
      if (op_i >= 4'd4 && op_i <= 4'd6)
         p_logic_clears_nc_r5: assert (flags_o[FL_N] == 1'b0 && flags_o[FL_C] == 1'b0);
      // R3: subtracting forms report N set
      if (op_i == 4'd2 || op_i == 4'd3 || op_i == 4'd7 || op_i == 4'd9 || op_i == 4'd10)
         p_sub_sets_n_r3: assert (flags_o[FL_N] == 1'b1);
      // R6: zero flag tracks the written result (compare excluded)
      if (op_i <= 4'd10 && op_i != 4'd7)
         p_zero_matches_r6: assert (flags_o[FL_Z] == (res_o == '0));
      // R9: complement inverts the accumulator, leaves S Z PV C alone
      if (op_i == 4'd11)
         p_cpl_r9: assert (res_o == ~acc_i && flags_o[FL_C] == flags_i[FL_C]
                           && flags_o[FL_S] == flags_i[FL_S]);
      // R11: reserved codes are transparent
      if (op_i >= 4'd14)
         p_reserved_r11: assert (res_o == acc_i && flags_o == flags_i);
   end
endmodule

bind acc_alu acc_alu_chk #(.WIDTH(WIDTH)) u_acc_alu_chk (
   .acc_i(acc_i), .opnd_i(opnd_i), .op_i(op_i), .flags_i(flags_i),
   .res_o(res_o), .flags_o(flags_o)
);

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 150000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] acc, opnd, res;
   logic [3:0] op;
   logic [5:0] fin, fout;
   int         n_vec = 0;
   int         n_bad = 0;
   bit         done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   acc_alu u_acc_alu (
      .acc_i(acc), .opnd_i(opnd), .op_i(op), .flags_i(fin),
      .res_o(res), .flags_o(fout)
   );

   // Reference model built from the requirements; returns {result, S,Z,H,PV,N,C}
   function automatic logic [13:0] model(int o, int a, int b, int f);
      int r, t, ci;
      logic [5:0] fl;
      fl = f[5:0];
      ci = f & 1;
      r  = a;
      case (o)
         0, 1: begin // R2
            if (o == 0) ci = 0;
            t = a + b + ci; r = t & 255;
            fl[3] = ((a & 15) + (b & 15) + ci) > 15;
            fl[2] = (((a ^ b) & 128) == 0) && (((a ^ r) & 128) != 0);
            fl[1] = 1'b0; fl[0] = t > 255;
         end
         2, 3, 7: begin // R3, R4
            if (o == 2 || o == 7) ci = 0;
            t = a - b - ci; r = t & 255;
            fl[3] = ((a & 15) - (b & 15) - ci) < 0;
            fl[2] = (((a ^ b) & 128) != 0) && (((a ^ r) & 128) != 0);
            fl[1] = 1'b1; fl[0] = t < 0;
         end
         4, 5, 6: begin // R5
            r = (o == 4) ? (a & b) : (o == 5) ? (a ^ b) : (a | b);
            fl[3] = (o == 4);
            fl[2] = ($countones(r[7:0]) % 2) == 0;
            fl[1] = 1'b0; fl[0] = 1'b0;
         end
         8: begin r = (a + 1) & 255; fl[3] = (a & 15) == 15; fl[2] = a == 127; fl[1] = 1'b0; end
         9: begin r = (a - 1) & 255; fl[3] = (a & 15) == 0;  fl[2] = a == 128; fl[1] = 1'b1; end
         10: begin
            r = (256 - a) & 255; fl[3] = (a & 15) != 0; fl[2] = a == 128;
            fl[1] = 1'b1; fl[0] = a != 0;
         end
         11: begin r = (~a) & 255; fl[3] = 1'b1; fl[1] = 1'b1; end
         12: begin fl[0] = 1'b1; fl[3] = 1'b0; fl[1] = 1'b0; end
         13: begin fl[0] = ~f[0]; fl[1] = 1'b0; end
         default: ;
      endcase
      if (o <= 10) begin // R6
         t = (o == 7) ? ((a - b) & 255) : r;
         fl[5] = (t & 128) != 0;
         fl[4] = (t == 0);
      end
      if (o == 7) r = a;
      return {r[7:0], fl};
   endfunction

   function automatic string tag_of(int o);
      case (o)
         0, 1:    return "R2";
         2, 3:    return "R3";
         7:       return "R4";
         4, 5, 6: return "R5";
         8, 9:    return "R7";
         10:      return "R8";
         11:      return "R9";
         12, 13:  return "R10";
         default: return "R11";
      endcase
   endfunction

   task automatic apply(int o, int a, int b, int f);
      logic [13:0] exp;
      string       tg;
      op = o[3:0]; acc = a[7:0]; opnd = b[7:0]; fin = f[5:0];
      #1;
      exp = model(o, a, b, f);
      n_vec++;
      if ({res, fout} !== exp) begin
         n_bad++;
         tg = tag_of(o);
         if (res === exp[13:6] && fout[3:0] === exp[3:0]) tg = "R6";
         if (n_bad <= 20)
            $display("FAIL %s op=%0d acc=%02h opnd=%02h fin=%02h: got res=%02h flags=%02h, expected res=%02h flags=%02h",
                     tg, o, a, b, f, res, fout, exp[13:6], exp[5:0]);
      end
   endtask

   initial begin : watchdog
      for (int c = 0; c < WD_CYCLES && !done; c++) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin : stim
      op = '0; acc = '0; opnd = '0; fin = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      // Idle state: code 0 with all-zero inputs gives zero result and only Z set (R2, R6)
      apply(0, 0, 0, 0);
      // Directed corners: R2 overflow, R3 borrow, R4 equal, R8 0x80, R7 wrap
      apply(0, 8'h7F, 8'h01, 0);
      apply(2, 8'h00, 8'h01, 0);
      apply(7, 8'h42, 8'h42, 0);
      apply(10, 8'h80, 0, 0);
      apply(10, 8'h00, 0, 1);
      apply(8, 8'hFF, 0, 1);
      apply(9, 8'h00, 0, 0);
      apply(14, 8'h5A, 8'hA5, 6'h2B);
      // R1: codes 0..7 against every operand pair, carry-in varied with the operands
      for (int o = 0; o < 8; o++)
         for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
               apply(o, a, b, (a * 7 + b * 3 + o) & 63);
      // R7..R11: single-operand codes against every accumulator and flag vector
      for (int o = 8; o < 16; o++)
         for (int a = 0; a < 256; a++)
            for (int f = 0; f < 64; f++)
               apply(o, a, (a * 5) & 255, f);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule